// File: doc/BRIEF.md
# Shared Byte FIFO with Threshold and Status Interrupts

This block is one byte-wide queue that two serial-bus engines share: a master engine and a slave engine. Only one engine owns the queue at any time. The owner sees the real empty, full and interrupt state. The other engine always sees an empty queue, with no full indication and no interrupt. Software picks the owner. A request to move ownership is taken only while the queue holds no data; a request made at any other time has no effect.

Software also sets a fill-level trigger and a direction. In transmit direction the service interrupt raises when the level falls to or below the trigger. In receive direction it raises when the level climbs to or above it. Full and empty interrupts and two sticky error flags complete the status word. Every bit has a raw form, a masked form and a write-one-to-clear input. The three level-based bits are set only on a transition into their condition. Clearing one of them while its condition still holds therefore keeps it clear until the condition ends and then returns.

Top module: `bus_share_fifo`

## Requirements
- R1: After reset the fill level is 0, the owner is the master (owner = 0), every raw status bit is 0, and both engines see empty = 1, full = 0 and interrupt = 0.
- R2: Bytes leave `rd_data` in the order they were written. `fill_level` reports 0 to 8 stored bytes, and the queue holds at most 8.
- R3: A write while the level is 8 is dropped, even when a read happens in the same cycle. Contents and level stay as they were, and raw bit 3 (overflow) is set and stays set until cleared.
- R4: A read while the level is 0 is dropped. The level stays 0, and raw bit 4 (underflow) is set and stays set until cleared.
- R5: With `cfg_tx` = 1, raw bit 0 (service) is set in the cycle the level moves from above `cfg_trig` to at or below it.
- R6: With `cfg_tx` = 0, raw bit 0 is set in the cycle the level moves from below `cfg_trig` to at or above it.
- R7: Raw bit 1 (full) is set when the level reaches 8. Raw bit 2 (empty) is set when the level reaches 0 from a nonzero value. Neither is set just by coming out of reset.
- R8: If raw bit 2 is cleared while the queue stays empty, the bit stays 0 until the queue receives data and drains again.
- R9: A 1 on `irq_clr[i]` clears raw bit i on the next edge, but a new set event in the same cycle wins. `irq_masked` is raw AND `irq_mask`, and `irq_out` is the OR of `irq_masked`.
- R10: Engine index 0 is the master and index 1 the slave. The owning engine's `eng_empty`, `eng_full` and `eng_irq` follow the queue state and `irq_out`. The other engine reads empty = 1, full = 0 and interrupt = 0.
- R11: A pulse on `own_req` moves the owner to `own_sel` (0 master, 1 slave) only when the level is 0. Otherwise the owner does not change.
- R12: A write and a read in the same cycle, with the level neither 0 nor 8, leave the level unchanged and move one byte through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | Read strobe; removes the head byte |
| rd_data | output | 8 | Head byte; valid while level is nonzero |
| fill_level | output | 4 | Number of stored bytes |
| cfg_tx | input | 1 | 1 = transmit trigger sense, 0 = receive |
| cfg_trig | input | 4 | Trigger level |
| own_req | input | 1 | Ownership change request |
| own_sel | input | 1 | Requested owner, 0 master, 1 slave |
| owner | output | 1 | Current owner |
| irq_mask | input | 5 | Enable per status bit |
| irq_clr | input | 5 | Write-one-to-clear per status bit |
| irq_raw | output | 5 | Raw status: 0 service, 1 full, 2 empty, 3 overflow, 4 underflow |
| irq_masked | output | 5 | Raw status AND mask |
| irq_out | output | 1 | OR of masked status |
| eng_empty | output | 2 | Empty seen by each engine |
| eng_full | output | 2 | Full seen by each engine |
| eng_irq | output | 2 | Interrupt seen by each engine |

## Verification
On every cycle the assertions check several invariants. The level never exceeds the depth, and a one-sided write or read changes it by exactly one. Overflow and underflow attempts always leave their flag set. A clear with no new set empties the bit. The owner changes only out of an empty state, and at most one engine ever sees data. Only the bench's scenarios can show that the data keeps its order, and that the trigger fires in the correct cycle for each direction. They also show that clearing the empty interrupt while the queue stays empty does not bring it back, and that a set in the same cycle wins over a clear.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    localparam int NUM_IRQ   = 5;
    localparam int IRQ_TRIG  = 0;
    localparam int IRQ_FULL  = 1;
    localparam int IRQ_EMPTY = 2;
    localparam int IRQ_OVF   = 3;
    localparam int IRQ_UDF   = 4;
    localparam int NUM_ENG   = 2;

    typedef enum logic {
        OWN_MASTER = 1'b0,
        OWN_SLAVE  = 1'b1
    } owner_e;
endpackage

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count_q,
    output logic [CNT_W-1:0]  count_d
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wr_ptr;
        logic [PTR_W-1:0]             rd_ptr;
        logic [CNT_W-1:0]             cnt;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr_ptr] = wr_data;
            st_d.wr_ptr = (st_q.wr_ptr == LAST_PTR) ? '0 : st_q.wr_ptr + PTR_W'(1);
        end
        if (pop) begin
            st_d.rd_ptr = (st_q.rd_ptr == LAST_PTR) ? '0 : st_q.rd_ptr + PTR_W'(1);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CNT_W'(1);
            2'b01:   st_d.cnt = st_q.cnt - CNT_W'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.mem[st_q.rd_ptr];
    assign count_q = st_q.cnt;
    assign count_d = st_d.cnt;

    // R2: a lone push raises the level by exactly one
    a_r2_push_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (count_q == CNT_W'($past(count_q) + CNT_W'(1))));
    // R2: a lone pop lowers the level by exactly one
    a_r2_pop_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (count_q == CNT_W'($past(count_q) - CNT_W'(1))));
endmodule

// File: rtl/sfifo_irq.sv
module sfifo_irq #(
    parameter int            N         = 5,
    parameter logic [N-1:0]  EDGE_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] mask,
    output logic [N-1:0] raw,
    output logic [N-1:0] masked
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] raw;
    } irq_t;

    irq_t ir_d, ir_q;
    logic [N-1:0] set_ev;

    for (genvar i = 0; i < N; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            assign set_ev[i] = cond[i] & ~ir_q.prev[i];
        end else begin : g_level
            assign set_ev[i] = cond[i];
        end
    end

    always_comb begin
        ir_d      = ir_q;
        ir_d.prev = cond;
        ir_d.raw  = (ir_q.raw & ~clr) | set_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q.prev <= '1;
            ir_q.raw  <= '0;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign raw    = ir_q.raw;
    assign masked = ir_q.raw & mask;

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R9: a clear with no live condition leaves the bit at zero
        a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !cond[i]) |=> !raw[i]);
        // R9: without a clear, a raw bit never drops by itself
        a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (raw[i] && !clr[i]) |=> raw[i]);
    end
endmodule

// File: rtl/sfifo_route.sv
module sfifo_route #(
    parameter int NUM_ENG = 2,
    localparam int SEL_W  = (NUM_ENG > 1) ? $clog2(NUM_ENG) : 1
) (
    input  logic [SEL_W-1:0]   owner,
    input  logic               q_empty,
    input  logic               q_full,
    input  logic               q_irq,
    output logic [NUM_ENG-1:0] eng_empty,
    output logic [NUM_ENG-1:0] eng_full,
    output logic [NUM_ENG-1:0] eng_irq
);
    for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
        logic owned;
        assign owned        = (owner == SEL_W'(e));
        assign eng_empty[e] = owned ? q_empty : 1'b1;
        assign eng_full[e]  = owned & q_full;
        assign eng_irq[e]   = owned & q_irq;
    end
endmodule

// File: rtl/bus_share_fifo.sv
module bus_share_fifo
    import sfifo_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rd_data,
    output logic [CNT_W-1:0]    fill_level,
    input  logic                cfg_tx,
    input  logic [CNT_W-1:0]    cfg_trig,
    input  logic                own_req,
    input  logic                own_sel,
    output logic                owner,
    input  logic [NUM_IRQ-1:0]  irq_mask,
    input  logic [NUM_IRQ-1:0]  irq_clr,
    output logic [NUM_IRQ-1:0]  irq_raw,
    output logic [NUM_IRQ-1:0]  irq_masked,
    output logic                irq_out,
    output logic [NUM_ENG-1:0]  eng_empty,
    output logic [NUM_ENG-1:0]  eng_full,
    output logic [NUM_ENG-1:0]  eng_irq
);
    localparam logic [CNT_W-1:0]   FULL_LVL  = CNT_W'(DEPTH);
    localparam logic [NUM_IRQ-1:0] EDGE_BITS = NUM_IRQ'((1 << IRQ_TRIG) | (1 << IRQ_FULL) | (1 << IRQ_EMPTY));

    typedef struct packed {
        owner_e own;
    } top_t;

    top_t tp_d, tp_q;

    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               is_empty, is_full, push_ok, pop_ok;
    logic [NUM_IRQ-1:0] cond;

    assign is_empty = (cnt_q == '0);
    assign is_full  = (cnt_q == FULL_LVL);
    assign push_ok  = wr_en & ~is_full;
    assign pop_ok   = rd_en & ~is_empty;

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push_ok),
        .pop     (pop_ok),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .count_q (cnt_q),
        .count_d (cnt_d)
    );

    always_comb begin
        cond            = '0;
        cond[IRQ_TRIG]  = cfg_tx ? (cnt_d <= cfg_trig) : (cnt_d >= cfg_trig);
        cond[IRQ_FULL]  = (cnt_d == FULL_LVL);
        cond[IRQ_EMPTY] = (cnt_d == '0);
        cond[IRQ_OVF]   = wr_en & is_full;
        cond[IRQ_UDF]   = rd_en & is_empty;
    end

    sfifo_irq #(.N(NUM_IRQ), .EDGE_MASK(EDGE_BITS)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond   (cond),
        .clr    (irq_clr),
        .mask   (irq_mask),
        .raw    (irq_raw),
        .masked (irq_masked)
    );

    assign irq_out = |irq_masked;

    always_comb begin
        tp_d = tp_q;
        if (own_req && is_empty) begin
            tp_d.own = owner_e'(own_sel);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q.own <= OWN_MASTER;
        else        tp_q     <= tp_d;
    end

    assign owner      = tp_q.own;
    assign fill_level = cnt_q;

    sfifo_route #(.NUM_ENG(NUM_ENG)) u_route (
        .owner     (owner),
        .q_empty   (is_empty),
        .q_full    (is_full),
        .q_irq     (irq_out),
        .eng_empty (eng_empty),
        .eng_full  (eng_full),
        .eng_irq   (eng_irq)
    );

    // R2: the level never passes the depth
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= FULL_LVL);
    // R3: a write into a full queue leaves the level and raises overflow
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill_level == FULL_LVL) |=> (fill_level <= FULL_LVL) && irq_raw[IRQ_OVF]);
    // R4: a lone read of an empty queue keeps it empty and raises underflow
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && fill_level == '0) |=> (fill_level == '0) && irq_raw[IRQ_UDF]);
    // R7: the last write into the queue raises the full bit
    a_r7_full_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en && fill_level == FULL_LVL - CNT_W'(1)) |=> irq_raw[IRQ_FULL]);
    // R11: the owner only moves out of an empty state
    a_r11_owner_moves_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != $past(owner)) |-> ($past(fill_level) == '0));
    // R11: a request while holding data is ignored
    a_r11_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level != '0) |=> $stable(owner));
    // R12: a balanced write and read keep the level
    a_r12_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && fill_level != '0 && fill_level != FULL_LVL) |=> $stable(fill_level));
    // R10: at most one engine ever sees data
    a_r10_one_view: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~eng_empty) <= 1);
endmodule

// File: tb/bus_share_fifo_tb.sv
module bus_share_fifo_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [3:0] fill_level;
    logic       cfg_tx = 1'b1;
    logic [3:0] cfg_trig = 4'd2;
    logic       own_req = 1'b0;
    logic       own_sel = 1'b0;
    logic       owner;
    logic [4:0] irq_mask = 5'h1F;
    logic [4:0] irq_clr = '0;
    logic [4:0] irq_raw, irq_masked;
    logic       irq_out;
    logic [1:0] eng_empty, eng_full, eng_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [7:0] sb[$];

    always #4 clk = ~clk;

    bus_share_fifo u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .fill_level(fill_level),
        .cfg_tx(cfg_tx), .cfg_trig(cfg_trig), .own_req(own_req), .own_sel(own_sel),
        .owner(owner), .irq_mask(irq_mask), .irq_clr(irq_clr), .irq_raw(irq_raw),
        .irq_masked(irq_masked), .irq_out(irq_out), .eng_empty(eng_empty),
        .eng_full(eng_full), .eng_irq(eng_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        wr_en = 0; rd_en = 0; own_req = 0; irq_clr = '0;
    endtask

    // driver: write, record expected byte in scoreboard if it fits
    task automatic push(input logic [7:0] d, input logic [4:0] c = '0);
        @(negedge clk);
        wr_en = 1; wr_data = d; irq_clr = c;
        if (sb.size() < 8) sb.push_back(d);
        step();
    endtask

    // monitor: compare head byte against scoreboard before it leaves
    task automatic pop(input string tag);
        @(negedge clk);
        rd_en = 1;
        if (sb.size() > 0) chk(tag, rd_data, sb.pop_front());
        step();
    endtask

    task automatic push_pop(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_data = d; rd_en = 1;
        chk("R12 head data", rd_data, sb.pop_front());
        sb.push_back(d);
        step();
    endtask

    task automatic clear(input logic [4:0] c);
        @(negedge clk);
        irq_clr = c;
        step();
    endtask

    task automatic request_owner(input logic s);
        @(negedge clk);
        own_req = 1; own_sel = s;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FIFO FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(posedge clk); #1;
        chk("R1 level", fill_level, 0);
        chk("R1 raw", irq_raw, 0);
        chk("R1 owner", owner, 0);
        chk("R1 eng_empty", eng_empty, 2'b11);
        chk("R1 eng_full", eng_full, 0);
        chk("R1 eng_irq", eng_irq, 0);

        for (int i = 0; i < 8; i++) push(8'hA0 + 8'(i));
        chk("R2 level full", fill_level, 8);
        chk("R7 full raw only", irq_raw, 5'h02);
        chk("R10 eng_full", eng_full, 2'b01);
        chk("R10 eng_empty", eng_empty, 2'b10);
        chk("R10 eng_irq", eng_irq, 2'b01);

        push(8'hEE);
        chk("R3 level kept", fill_level, 8);
        chk("R3 overflow raw", irq_raw, 5'h0A);

        request_owner(1'b1);
        chk("R11 busy ignored", owner, 0);

        clear(5'h1F);
        chk("R9 clear all", irq_raw, 0);

        for (int i = 0; i < 5; i++) pop("R2 order");
        chk("R5 above trigger", irq_raw, 0);
        pop("R2 order");
        chk("R5 trigger reached", irq_raw, 5'h01);
        pop("R2 order");
        pop("R2 order");
        chk("R7 empty raw", irq_raw, 5'h05);
        chk("R3 dropped byte absent", fill_level, 0);

        pop("R4 unused");
        chk("R4 level kept", fill_level, 0);
        chk("R4 underflow raw", irq_raw, 5'h15);

        clear(5'h04);
        chk("R8 cleared", irq_raw, 5'h11);
        repeat (3) step();
        chk("R8 stays clear", irq_raw, 5'h11);

        @(negedge clk); irq_mask = 5'h01; #1;
        chk("R9 masked", irq_masked, 5'h01);
        chk("R9 irq_out on", irq_out, 1);
        @(negedge clk); irq_mask = 5'h02; #1;
        chk("R9 masked none", irq_masked, 0);
        chk("R9 irq_out off", irq_out, 0);
        chk("R10 irq off", eng_irq, 0);
        @(negedge clk); irq_mask = 5'h1F;

        request_owner(1'b1);
        chk("R11 move when empty", owner, 1);
        push(8'hB0);
        chk("R10 slave view", eng_empty, 2'b01);
        chk("R10 slave irq", eng_irq, 2'b10);

        @(negedge clk); cfg_tx = 0; cfg_trig = 4'd3;
        step();
        clear(5'h1F);
        chk("R6 cleared", irq_raw, 0);
        push(8'hB1);
        chk("R6 below trigger", irq_raw, 0);
        push(8'hB2, 5'h01);
        chk("R6 R9 set wins", irq_raw, 5'h01);

        push_pop(8'hB3);
        chk("R12 level kept", fill_level, 3);
        pop("R12 order");
        pop("R12 order");
        pop("R12 order");
        chk("R7 empty again", irq_raw, 5'h05);
        chk("R2 drained", fill_level, 0);

        finish_run();
    end
endmodule